// File: doc/BRIEF.md
# Byte-Addressable Data Register File

This block holds a small set of general-purpose data registers for a datapath. Each register is one full-width word. It can also be reached through narrower views: its low half, the low byte of that half, or the high byte of that half. A narrow write updates only the bits of its own view and merges them into the stored word, so the rest of the register keeps its value. A narrow read returns the view zero-extended onto the full-width read bus.

There is one write port and two independent combinational read ports. Each read port has its own register index and view select, so an execution unit can fetch two operands of mixed widths in the same cycle. A write takes effect at the rising clock edge. A read of the register being written in that cycle returns the value held before the edge. A synchronous reset clears every register.

Top module: `prf_regfile_top`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared to zero, so any read in the cycle after reset returns zero.
- R2: A write with view code 00 (full word) replaces all 32 bits of the selected register with `wr_data`.
- R3: A write with view code 01 (low half) loads `wr_data[15:0]` into bits 15:0 and leaves bits 31:16 unchanged.
- R4: A write with view code 10 (low byte) loads `wr_data[7:0]` into bits 7:0 and leaves bits 31:8 unchanged.
- R5: A write with view code 11 (high byte of the low half) loads `wr_data[7:0]` into bits 15:8 and leaves bits 31:16 and 7:0 unchanged.
- R6: When `wr_en` is low, no register changes, whatever the other write inputs hold.
- R7: A write changes only the register named by `wr_idx`; the other registers keep their contents.
- R8: A read with view code 00 returns the full 32-bit register contents.
- R9: A read with view code 01 returns bits 15:0 of the register on bits 15:0 of the bus, with bits 31:16 zero.
- R10: A read with view code 10 returns register bits 7:0 on bus bits 7:0. A read with view code 11 returns register bits 15:8 on bus bits 7:0. In both cases bus bits 31:8 are zero.
- R11: The two read ports are independent: each returns its own index and view in the same cycle.
- R12: A read of the register written in the same cycle returns the old value. The new value appears in the cycle after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 2 | Register index to write |
| wr_view | input | 2 | Write view code (00 word, 01 low half, 10 low byte, 11 high byte) |
| wr_data | input | 32 | Write data; narrow views take their value from the low bits |
| ra_idx | input | 2 | Read port A register index |
| ra_view | input | 2 | Read port A view code |
| ra_data | output | 32 | Read port A data, zero-extended for narrow views |
| rb_idx | input | 2 | Read port B register index |
| rb_view | input | 2 | Read port B view code |
| rb_data | output | 32 | Read port B data, zero-extended for narrow views |

## Verification
Each register is first loaded with a distinct full word whose bytes all differ. A narrow write is then applied, and the register is read back through all four views, so a merge that touches the wrong lane shows up as a changed byte. Byte writes carry junk in the upper bits of `wr_data`, which exposes any leak of the high data bits into the register. Writes with the enable low, and reads of the same register in the write cycle, separate a correct edge-timed update from a missing enable gate or a write-through path. A sweep over every index and view, with both ports reading different places, checks the index decode and port independence.

// File: rtl/prf_pkg.sv
package prf_pkg;

   typedef enum logic [1:0] {
      VIEW_W32 = 2'b00,
      VIEW_W16 = 2'b01,
      VIEW_B0  = 2'b10,
      VIEW_B1  = 2'b11
   } view_e;

endpackage

// File: rtl/prf_write_lanes.sv
module prf_write_lanes #(
   parameter int WORD_W = 32
) (
   input  logic [1:0]              view,
   input  logic [WORD_W-1:0]       data,
   output logic [WORD_W/8-1:0]     lane_en,
   output logic [WORD_W-1:0]       lane_data
);
   import prf_pkg::*;

   localparam int BYTE_W = 8;
   localparam int LANES  = WORD_W / BYTE_W;
   localparam int HALF_L = LANES / 2;

   view_e v;
   assign v = view_e'(view);

   always_comb begin
      lane_en   = '0;
      lane_data = data;
      unique case (v)
         VIEW_W32: lane_en = '1;
         VIEW_W16: lane_en[HALF_L-1:0] = '1;
         VIEW_B0:  lane_en[0] = 1'b1;
         VIEW_B1: begin
            lane_en[1] = 1'b1;
            lane_data  = data << BYTE_W;
         end
         default:  lane_en = '0;
      endcase
   end

endmodule

// File: rtl/prf_reg_slot.sv
module prf_reg_slot #(
   parameter int WORD_W = 32
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    sel,
   input  logic [WORD_W/8-1:0]     lane_en,
   input  logic [WORD_W-1:0]       lane_data,
   output logic [WORD_W-1:0]       q
);
   localparam int BYTE_W = 8;
   localparam int LANES  = WORD_W / BYTE_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst)
            q[l*BYTE_W +: BYTE_W] <= '0;
         else if (sel && lane_en[l])
            q[l*BYTE_W +: BYTE_W] <= lane_data[l*BYTE_W +: BYTE_W];
      end
   end

endmodule

// File: rtl/prf_read_view.sv
module prf_read_view #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] word,
   input  logic [1:0]        view,
   output logic [WORD_W-1:0] data
);
   import prf_pkg::*;

   localparam int BYTE_W = 8;
   localparam int HALF_W = WORD_W / 2;

   view_e v;
   assign v = view_e'(view);

   always_comb begin
      data = '0;
      unique case (v)
         VIEW_W32: data = word;
         VIEW_W16: data[HALF_W-1:0] = word[HALF_W-1:0];
         VIEW_B0:  data[BYTE_W-1:0] = word[BYTE_W-1:0];
         VIEW_B1:  data[BYTE_W-1:0] = word[2*BYTE_W-1:BYTE_W];
         default:  data = '0;
      endcase
   end

endmodule

// File: rtl/prf_regfile_top.sv
module prf_regfile_top #(
   parameter int NUM_REGS = 4,
   parameter int WORD_W   = 32,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_view,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  ra_idx,
   input  logic [1:0]        ra_view,
   output logic [WORD_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   input  logic [1:0]        rb_view,
   output logic [WORD_W-1:0] rb_data
);
   localparam int LANES = WORD_W / 8;

   if (WORD_W % 32 != 0) begin : g_bad_width
      $error("WORD_W must be a multiple of 32");
   end
   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_depth
      $error("NUM_REGS must be a power of two, at least 2");
   end

   logic [LANES-1:0]  lane_en;
   logic [WORD_W-1:0] lane_data;
   logic [WORD_W-1:0] slot_q [NUM_REGS];

   prf_write_lanes #(.WORD_W(WORD_W)) u_lanes (
      .view      (wr_view),
      .data      (wr_data),
      .lane_en   (lane_en),
      .lane_data (lane_data)
   );

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(r));
      prf_reg_slot #(.WORD_W(WORD_W)) u_slot (
         .clk       (clk),
         .rst       (rst),
         .sel       (sel),
         .lane_en   (lane_en),
         .lane_data (lane_data),
         .q         (slot_q[r])
      );
   end

   prf_read_view #(.WORD_W(WORD_W)) u_rd_a (
      .word (slot_q[ra_idx]),
      .view (ra_view),
      .data (ra_data)
   );

   prf_read_view #(.WORD_W(WORD_W)) u_rd_b (
      .word (slot_q[rb_idx]),
      .view (rb_view),
      .data (rb_data)
   );

endmodule

// File: rtl/prf_regfile_chk.sv
module prf_regfile_chk #(
   parameter int WORD_W = 32,
   parameter int IDX_W  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [1:0]        wr_view,
   input logic [WORD_W-1:0] wr_data,
   input logic [IDX_W-1:0]  ra_idx,
   input logic [1:0]        ra_view,
   input logic [WORD_W-1:0] ra_data,
   input logic [IDX_W-1:0]  rb_idx,
   input logic [1:0]        rb_view,
   input logic [WORD_W-1:0] rb_data
);

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (ra_data == '0 && rb_data == '0));

   p_full_write_r2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en) && $past(wr_view) == 2'b00 &&
       ra_idx == $past(wr_idx) && ra_view == 2'b00)
      |-> ra_data == $past(wr_data));

   p_low_byte_write_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(wr_en) && $past(wr_view) == 2'b10 &&
       ra_idx == $past(wr_idx) && ra_view == 2'b10)
      |-> ra_data[7:0] == $past(wr_data[7:0]));

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(wr_en) && $stable(ra_idx) && $stable(ra_view))
      |-> $stable(ra_data));

   p_half_zero_ext_r9: assert property (@(posedge clk) disable iff (rst)
      (rb_view == 2'b01) |-> rb_data[WORD_W-1:16] == '0);

   p_byte_zero_ext_r10: assert property (@(posedge clk) disable iff (rst)
      (ra_view[1] || rb_view[1]) |->
      ((!ra_view[1] || ra_data[WORD_W-1:8] == '0) &&
       (!rb_view[1] || rb_data[WORD_W-1:8] == '0)));

endmodule

bind prf_regfile_top prf_regfile_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_prf_regfile_top.sv
`timescale 1ns/1ps
module sim_prf_regfile_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_idx = '0, wr_view = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  ra_idx = '0, ra_view = '0, rb_idx = '0, rb_view = '0;
   logic [31:0] ra_data, rb_data;

   int checks = 0;
   int errors = 0;
   logic [31:0] mdl [4];

   always #10 clk = ~clk;

   prf_regfile_top u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_view(wr_view), .wr_data(wr_data),
      .ra_idx(ra_idx), .ra_view(ra_view), .ra_data(ra_data),
      .rb_idx(rb_idx), .rb_view(rb_view), .rb_data(rb_data)
   );

   function automatic logic [31:0] mread(input logic [1:0] idx, input logic [1:0] v);
      logic [31:0] w = mdl[idx];
      case (v)
         2'b00:   return w;
         2'b01:   return {16'h0, w[15:0]};
         2'b10:   return {24'h0, w[7:0]};
         default: return {24'h0, w[15:8]};
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input string tag, input bit r, input bit we,
                      input logic [1:0] wi, input logic [1:0] wv, input logic [31:0] wd,
                      input logic [1:0] ai, input logic [1:0] av,
                      input logic [1:0] bi, input logic [1:0] bv);
      @(negedge clk);
      rst = r; wr_en = we; wr_idx = wi; wr_view = wv; wr_data = wd;
      ra_idx = ai; ra_view = av; rb_idx = bi; rb_view = bv;
      #1;
      if (!r) begin
         check(tag, ra_data, mread(ai, av));
         check(tag, rb_data, mread(bi, bv));
      end
      @(posedge clk);
      if (r) begin
         for (int i = 0; i < 4; i++) mdl[i] = '0;
      end else if (we) begin
         case (wv)
            2'b00:   mdl[wi] = wd;
            2'b01:   mdl[wi][15:0] = wd[15:0];
            2'b10:   mdl[wi][7:0] = wd[7:0];
            default: mdl[wi][15:8] = wd[7:0];
         endcase
      end
   endtask

   task automatic sweep(input string tag);
      for (int i = 0; i < 4; i++)
         for (int v = 0; v < 4; v++)
            cyc(tag, 0, 0, 0, 0, 32'hDEAD_BEEF, 2'(i), 2'(v), 2'(3 - i), 2'(3 - v));
   endtask

   initial begin
      for (int i = 0; i < 4; i++) mdl[i] = 32'hFFFF_FFFF;
      cyc("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc("R1", 1, 1, 1, 0, 32'h1234_5678, 0, 0, 0, 0);
      sweep("R1");
      cyc("R2", 0, 1, 0, 2'b00, 32'hA1B2_C3D4, 0, 0, 1, 0);
      cyc("R2", 0, 1, 1, 2'b00, 32'h1122_3344, 0, 0, 0, 0);
      cyc("R2", 0, 1, 2, 2'b00, 32'h5566_7788, 1, 0, 0, 0);
      cyc("R2", 0, 1, 3, 2'b00, 32'h99AA_BBCC, 2, 0, 1, 0);
      cyc("R8", 0, 0, 0, 0, 0, 3, 0, 0, 0);
      cyc("R3", 0, 1, 1, 2'b01, 32'hFFFF_5A5A, 1, 0, 1, 1);
      cyc("R3", 0, 0, 0, 0, 0, 1, 0, 1, 1);
      cyc("R4", 0, 1, 2, 2'b10, 32'hFFFF_FF77, 2, 0, 2, 2);
      cyc("R4", 0, 0, 0, 0, 0, 2, 0, 2, 2);
      cyc("R5", 0, 1, 3, 2'b11, 32'hFFFF_FFEE, 3, 0, 3, 3);
      cyc("R5", 0, 0, 0, 0, 0, 3, 0, 3, 2);
      cyc("R6", 0, 0, 0, 2'b00, 32'h0BAD_F00D, 0, 0, 0, 1);
      cyc("R6", 0, 0, 0, 2'b11, 32'h0000_00AB, 0, 0, 0, 3);
      cyc("R6", 0, 0, 0, 0, 0, 0, 0, 0, 3);
      sweep("R7");
      cyc("R12", 0, 1, 0, 2'b00, 32'hCAFE_0001, 0, 0, 0, 1);
      cyc("R12", 0, 1, 0, 2'b10, 32'h0000_0099, 0, 0, 0, 2);
      cyc("R12", 0, 0, 0, 0, 0, 0, 0, 0, 2);
      sweep("R9");
      for (int k = 0; k < 32; k++)
         cyc("R10", 0, 1, 2'(k), 2'(k >> 2), 32'h1357_9BDF * (k + 1),
             2'(k + 1), 2'(k >> 1), 2'(k + 2), 2'(k));
      sweep("R11");
      cyc("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
      sweep("R1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule